// File: doc/BRIEF.md
# Alignment Marker Error Injector

This block sits in the transmit path of a multi-lane 64B/66B PCS lane group, just after marker insertion. Every cycle it takes one 66-bit block per lane, together with a common valid flag and a common flag that marks alignment-marker blocks. Markers appear on all lanes in the same cycle. On lanes chosen by software, it flips bits of selected blocks by XORing them with a configured mask. The mask has one 2-bit field for the sync header and eight 8-bit fields, one for each marker byte. Two of those bytes are the parity bytes.

A start pulse captures the whole configuration and begins injection. The configuration covers the mask, the lane enables, whether payload blocks are eligible, and the schedule. In continuous mode every eligible block is corrupted until a stop pulse arrives. In burst mode the block corrupts a run of eligible blocks, skips a gap of eligible blocks, and repeats this a configured number of times. It then raises a done flag. When only markers are eligible, only markers advance the burst and gap counters. Marker generation, scrambling and serialization are handled elsewhere.

Top module: `am_err_inject`

## Requirements
- R1: A corrupted block leaves the block equal to the input XOR the captured mask. The sync-header mask lands on block bits [1:0], and marker byte k's mask lands on bits [9+8k:2+8k] for k = 0..7. These are bytes 0, 1, 2, parity A, 4, 5, 6, parity B, so the parity bytes are k = 3 and k = 7.
- R2: A lane whose captured enable bit is 0 always passes its block unchanged.
- R3: With payload disabled (cfg_with_payload = 0), only blocks flagged as markers are eligible. Non-marker blocks pass unchanged, and blocks with in_vld = 0 are never corrupted and never counted.
- R4: With cfg_with_payload = 1, every valid block is eligible, whether it is a marker or not.
- R5: With cfg_burst_mode = 0, every eligible block on an enabled lane is corrupted. This runs from the cycle after start until the cycle of stop, inclusive.
- R6: With cfg_burst_mode = 1, the block corrupts cfg_burst_len consecutive eligible blocks. It then passes cfg_burst_gap eligible blocks unchanged, where 0 means bursts are back to back. This repeats for cfg_burst_cnt bursts. A length or count of 0 is treated as 1.
- R7: In burst mode, busy falls and done rises in the cycle after the last corrupted block. Done stays high until the next accepted start clears it.
- R8: A stop pulse returns the block to idle, with busy low in the next cycle. The block present in the stop cycle is still handled by the running schedule. When start and stop arrive together, stop wins and done is left unchanged.
- R9: The configuration is captured only at start. Changing the configuration inputs while busy has no effect until the next start.
- R10: Outputs are registered with one cycle of latency. out_vld and out_marker repeat in_vld and in_marker of the previous cycle.
- R11: After reset all outputs are 0, busy is low and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Start pulse: captures the configuration and starts injection |
| stop | input | 1 | Stop pulse: returns the block to idle |
| cfg_sh_mask | input | 2 | XOR mask for the sync header |
| cfg_byte_mask | input | 64 | XOR mask for marker bytes; byte k in bits [8k+7:8k] |
| cfg_lane_en | input | LANES | Per-lane injection enable |
| cfg_with_payload | input | 1 | 1: payload blocks are eligible too |
| cfg_burst_mode | input | 1 | 0: continuous, 1: burst schedule |
| cfg_burst_len | input | LEN_W | Eligible blocks corrupted per burst |
| cfg_burst_gap | input | GAP_W | Eligible blocks skipped between bursts |
| cfg_burst_cnt | input | CNT_W | Number of bursts |
| in_vld | input | 1 | Input blocks valid |
| in_marker | input | 1 | Input blocks are alignment markers |
| in_blk | input | LANES*66 | Input blocks; lane l in bits [66l+65:66l] |
| out_vld | output | 1 | Output blocks valid |
| out_marker | output | 1 | Output blocks are alignment markers |
| out_blk | output | LANES*66 | Output blocks, same lane layout |
| busy | output | 1 | A schedule is running |
| done | output | 1 | The final burst has completed |

## Verification
The bench drives random blocks with random valid and marker flags under several patterns. A lane-enable pattern with alternating lanes separates per-lane gating from global gating. Marker-only runs against payload runs separate the eligibility rule from the counting rule. Small burst lengths, gaps of zero and non-zero, and several burst counts expose off-by-one faults in the scheduler. Directed cases cover stop mid-burst, start and stop arriving together, and configuration changes while busy. Randomised configurations then mix all of these.

// File: rtl/am_err_pkg.sv
package am_err_pkg;

    localparam int BLK_W    = 66;
    localparam int SH_W     = 2;
    localparam int AM_BYTES = 8;
    localparam int BYTE_W   = 8;

    typedef enum logic [1:0] {
        SCH_IDLE = 2'd0,
        SCH_CONT = 2'd1,
        SCH_HIT  = 2'd2,
        SCH_GAP  = 2'd3
    } sch_state_e;

    // Field layout matches the 66-bit block: sync header in the low bits.
    typedef struct packed {
        logic [AM_BYTES*BYTE_W-1:0] bytes;
        logic [SH_W-1:0]            sh;
    } blk_mask_t;

    function automatic logic [BLK_W-1:0] apply_mask(
        input logic [BLK_W-1:0] blk,
        input blk_mask_t        m,
        input logic             en
    );
        return en ? (blk ^ BLK_W'(m)) : blk;
    endfunction

endpackage

// File: rtl/am_err_sched.sv
module am_err_sched
    import am_err_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LEN_W = 24,
    parameter int GAP_W = 24,
    parameter int CNT_W = 46
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          start,
    input  logic                          stop,
    input  logic [SH_W-1:0]               cfg_sh_mask,
    input  logic [AM_BYTES*BYTE_W-1:0]    cfg_byte_mask,
    input  logic [LANES-1:0]              cfg_lane_en,
    input  logic                          cfg_with_payload,
    input  logic                          cfg_burst_mode,
    input  logic [LEN_W-1:0]              cfg_burst_len,
    input  logic [GAP_W-1:0]              cfg_burst_gap,
    input  logic [CNT_W-1:0]              cfg_burst_cnt,
    input  logic                          in_vld,
    input  logic                          in_marker,
    output logic                          hit,
    output blk_mask_t                     mask_q,
    output logic [LANES-1:0]              lane_en_q,
    output logic                          pay_q,
    output logic                          busy,
    output logic                          done
);

    sch_state_e       state_q;
    logic [LEN_W-1:0] len_q, len_left;
    logic [GAP_W-1:0] gap_q, gap_left;
    logic [CNT_W-1:0] bursts_left;
    logic             elig;

    assign elig = in_vld && (in_marker || pay_q);
    assign hit  = elig && (state_q == SCH_CONT || state_q == SCH_HIT);
    assign busy = (state_q != SCH_IDLE);

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= SCH_IDLE;
            mask_q      <= '0;
            lane_en_q   <= '0;
            pay_q       <= 1'b0;
            len_q       <= '0;
            gap_q       <= '0;
            len_left    <= '0;
            gap_left    <= '0;
            bursts_left <= '0;
            done        <= 1'b0;
        end else if (stop) begin
            state_q <= SCH_IDLE;
        end else if (start) begin
            mask_q.sh    <= cfg_sh_mask;
            mask_q.bytes <= cfg_byte_mask;
            lane_en_q    <= cfg_lane_en;
            pay_q        <= cfg_with_payload;
            len_q        <= (cfg_burst_len == '0) ? LEN_W'(1) : cfg_burst_len;
            len_left     <= (cfg_burst_len == '0) ? LEN_W'(1) : cfg_burst_len;
            gap_q        <= cfg_burst_gap;
            bursts_left  <= (cfg_burst_cnt == '0) ? CNT_W'(1) : cfg_burst_cnt;
            done         <= 1'b0;
            state_q      <= cfg_burst_mode ? SCH_HIT : SCH_CONT;
        end else if (elig) begin
            unique case (state_q)
                SCH_HIT: begin
                    if (len_left == LEN_W'(1)) begin
                        if (bursts_left == CNT_W'(1)) begin
                            state_q <= SCH_IDLE;
                            done    <= 1'b1;
                        end else begin
                            bursts_left <= bursts_left - CNT_W'(1);
                            len_left    <= len_q;
                            if (gap_q != '0) begin
                                state_q  <= SCH_GAP;
                                gap_left <= gap_q;
                            end
                        end
                    end else begin
                        len_left <= len_left - LEN_W'(1);
                    end
                end
                SCH_GAP: begin
                    if (gap_left == GAP_W'(1)) state_q <= SCH_HIT;
                    else                       gap_left <= gap_left - GAP_W'(1);
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/am_err_lane.sv
module am_err_lane
    import am_err_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [BLK_W-1:0] blk_i,
    input  logic             hit,
    input  logic             lane_en,
    input  blk_mask_t        mask,
    output logic [BLK_W-1:0] blk_o
);

    always_ff @(posedge clk) begin
        if (rst) blk_o <= '0;
        else     blk_o <= apply_mask(blk_i, mask, hit && lane_en);
    end

endmodule

// File: rtl/am_err_inject.sv
module am_err_inject
    import am_err_pkg::*;
#(
    parameter int LANES = 4,
    parameter int LEN_W = 24,
    parameter int GAP_W = 24,
    parameter int CNT_W = 46
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         start,
    input  logic                         stop,
    input  logic [1:0]                   cfg_sh_mask,
    input  logic [63:0]                  cfg_byte_mask,
    input  logic [LANES-1:0]             cfg_lane_en,
    input  logic                         cfg_with_payload,
    input  logic                         cfg_burst_mode,
    input  logic [LEN_W-1:0]             cfg_burst_len,
    input  logic [GAP_W-1:0]             cfg_burst_gap,
    input  logic [CNT_W-1:0]             cfg_burst_cnt,
    input  logic                         in_vld,
    input  logic                         in_marker,
    input  logic [LANES*66-1:0]          in_blk,
    output logic                         out_vld,
    output logic                         out_marker,
    output logic [LANES*66-1:0]          out_blk,
    output logic                         busy,
    output logic                         done
);

    localparam int BUS_W = LANES * BLK_W;

    logic             hit;
    blk_mask_t        mask_q;
    logic [LANES-1:0] lane_en_q;
    logic             pay_q;

    am_err_sched #(
        .LANES(LANES), .LEN_W(LEN_W), .GAP_W(GAP_W), .CNT_W(CNT_W)
    ) i_sched (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .cfg_sh_mask(cfg_sh_mask), .cfg_byte_mask(cfg_byte_mask),
        .cfg_lane_en(cfg_lane_en), .cfg_with_payload(cfg_with_payload),
        .cfg_burst_mode(cfg_burst_mode), .cfg_burst_len(cfg_burst_len),
        .cfg_burst_gap(cfg_burst_gap), .cfg_burst_cnt(cfg_burst_cnt),
        .in_vld(in_vld), .in_marker(in_marker),
        .hit(hit), .mask_q(mask_q), .lane_en_q(lane_en_q), .pay_q(pay_q),
        .busy(busy), .done(done)
    );

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        am_err_lane i_lane (
            .clk(clk), .rst(rst),
            .blk_i(in_blk[l*BLK_W +: BLK_W]),
            .hit(hit), .lane_en(lane_en_q[l]), .mask(mask_q),
            .blk_o(out_blk[l*BLK_W +: BLK_W])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_vld    <= 1'b0;
            out_marker <= 1'b0;
        end else begin
            out_vld    <= in_vld;
            out_marker <= in_marker;
        end
    end

    if (BUS_W != $bits(in_blk)) begin : g_bad_width
        initial $fatal(1, "lane bus width mismatch");
    end

endmodule

// File: rtl/am_err_inject_chk.sv
module am_err_inject_chk #(
    parameter int LANES = 4
) (
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                stop,
    input logic                in_vld,
    input logic                in_marker,
    input logic [LANES*66-1:0] in_blk,
    input logic                out_vld,
    input logic                out_marker,
    input logic [LANES*66-1:0] out_blk,
    input logic                busy,
    input logic                done,
    input logic                pay_q,
    input logic [LANES-1:0]    lane_en_q
);

    for (genvar l = 0; l < LANES; l++) begin : g_lane_chk
        assert_lane_off_R2: assert property (@(posedge clk) disable iff (rst)
            !lane_en_q[l] |=> out_blk[l*66 +: 66] == $past(in_blk[l*66 +: 66]));
    end

    assert_marker_only_R3: assert property (@(posedge clk) disable iff (rst)
        (!pay_q && !in_marker) |=> out_blk == $past(in_blk));

    assert_invalid_untouched_R3: assert property (@(posedge clk) disable iff (rst)
        !in_vld |=> out_blk == $past(in_blk));

    assert_idle_pass_R8: assert property (@(posedge clk) disable iff (rst)
        !busy |=> out_blk == $past(in_blk));

    assert_stop_idle_R8: assert property (@(posedge clk) disable iff (rst)
        stop |=> !busy);

    assert_start_busy_R9: assert property (@(posedge clk) disable iff (rst)
        (start && !stop) |=> busy && !done);

    assert_done_excl_R7: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    assert_done_rise_R7: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> $past(busy));

    assert_flag_delay_R10: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (out_vld == $past(in_vld)) && (out_marker == $past(in_marker)));

endmodule

bind am_err_inject am_err_inject_chk #(.LANES(LANES)) i_chk (
    .clk(clk), .rst(rst), .start(start), .stop(stop),
    .in_vld(in_vld), .in_marker(in_marker), .in_blk(in_blk),
    .out_vld(out_vld), .out_marker(out_marker), .out_blk(out_blk),
    .busy(busy), .done(done), .pay_q(pay_q), .lane_en_q(lane_en_q)
);

// File: tb/test_am_err_inject.sv
module test_am_err_inject;

    localparam int LANES = 4;
    localparam int LEN_W = 24;
    localparam int GAP_W = 24;
    localparam int CNT_W = 46;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic                 start = 0, stop = 0;
    logic [1:0]           c_sh = 0;
    logic [63:0]          c_bytes = 0;
    logic [LANES-1:0]     c_en = 0;
    logic                 c_pay = 0, c_burst = 0;
    logic [LEN_W-1:0]     c_len = 1;
    logic [GAP_W-1:0]     c_gap = 1;
    logic [CNT_W-1:0]     c_cnt = 1;
    logic                 in_vld = 0, in_marker = 0;
    logic [LANES*66-1:0]  in_blk = '0;
    logic                 out_vld, out_marker, busy, done;
    logic [LANES*66-1:0]  out_blk;

    am_err_inject #(.LANES(LANES), .LEN_W(LEN_W), .GAP_W(GAP_W), .CNT_W(CNT_W)) i_am_err_inject (
        .clk(clk), .rst(rst), .start(start), .stop(stop),
        .cfg_sh_mask(c_sh), .cfg_byte_mask(c_bytes), .cfg_lane_en(c_en),
        .cfg_with_payload(c_pay), .cfg_burst_mode(c_burst),
        .cfg_burst_len(c_len), .cfg_burst_gap(c_gap), .cfg_burst_cnt(c_cnt),
        .in_vld(in_vld), .in_marker(in_marker), .in_blk(in_blk),
        .out_vld(out_vld), .out_marker(out_marker), .out_blk(out_blk),
        .busy(busy), .done(done)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // Reference model state, built from the requirements.
    int          m_st = 0;          // 0 idle, 1 continuous, 2 in burst, 3 in gap
    logic [65:0] m_mask = '0;
    logic [LANES-1:0] m_en = '0;
    bit          m_pay = 0, m_done = 0;
    longint      m_len = 1, m_gap = 0, m_len_left = 0, m_gap_left = 0, m_bursts = 0;
    int          hits_seen = 0;

    function automatic logic [65:0] rnd_blk();
        logic [95:0] r;
        r = {$urandom(), $urandom(), $urandom()};
        return r[65:0];
    endfunction

    function automatic logic [65:0] mask_of(logic [1:0] sh, logic [63:0] b);
        return {b, sh};
    endfunction

    task automatic check(string tag, bit ok, string act, string exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %s expected %s", tag, act, exp);
        end
    endtask

    // One cycle: drive at negedge, predict, compare at the following negedge.
    task automatic step(string tag, bit vld, bit mk, bit st, bit sp);
        logic [LANES*66-1:0] exp_blk;
        bit elig, hit;
        in_vld = vld; in_marker = mk; start = st; stop = sp;
        for (int l = 0; l < LANES; l++) in_blk[l*66 +: 66] = rnd_blk();
        elig = vld && (mk || m_pay);
        hit  = elig && (m_st == 1 || m_st == 2);
        if (hit) hits_seen++;
        for (int l = 0; l < LANES; l++)
            exp_blk[l*66 +: 66] = (hit && m_en[l]) ? in_blk[l*66 +: 66] ^ m_mask
                                                   : in_blk[l*66 +: 66];
        if (sp) m_st = 0;
        else if (st) begin
            m_mask = mask_of(c_sh, c_bytes); m_en = c_en; m_pay = c_pay;
            m_len = (c_len == 0) ? 1 : longint'(c_len);
            m_gap = longint'(c_gap);
            m_bursts = (c_cnt == 0) ? 1 : longint'(c_cnt);
            m_len_left = m_len; m_done = 0;
            m_st = c_burst ? 2 : 1;
        end else if (elig && m_st == 2) begin
            if (m_len_left == 1) begin
                if (m_bursts == 1) begin m_st = 0; m_done = 1; end
                else begin
                    m_bursts--; m_len_left = m_len;
                    if (m_gap != 0) begin m_st = 3; m_gap_left = m_gap; end
                end
            end else m_len_left--;
        end else if (elig && m_st == 3) begin
            if (m_gap_left == 1) m_st = 2; else m_gap_left--;
        end
        @(negedge clk);
        start = 0; stop = 0;
        check({tag, " blocks"}, out_blk === exp_blk,
              $sformatf("%h", out_blk), $sformatf("%h", exp_blk));
        check({tag, " R10 flags"}, out_vld === vld && out_marker === mk,
              $sformatf("%b%b", out_vld, out_marker), $sformatf("%b%b", vld, mk));
        check({tag, " status"}, busy === (m_st != 0) && done === m_done,
              $sformatf("busy=%b done=%b", busy, done),
              $sformatf("busy=%b done=%b", m_st != 0, m_done));
    endtask

    task automatic rnd_steps(string tag, int n, int mk_pct);
        for (int i = 0; i < n; i++)
            step(tag, ($urandom_range(99) < 90), ($urandom_range(99) < mk_pct), 0, 0);
    endtask

    task automatic set_cfg(bit burst, bit pay, logic [LANES-1:0] en,
                           longint len, longint gap, longint cnt);
        c_sh = 2'($urandom()); c_bytes = {$urandom(), $urandom()};
        c_en = en; c_pay = pay; c_burst = burst;
        c_len = LEN_W'(len); c_gap = GAP_W'(gap); c_cnt = CNT_W'(cnt);
    endtask

    initial begin
        #3_000_000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd7151));
        @(negedge clk); @(negedge clk);
        rst = 0;
        // R11: reset state
        check("R11 reset", out_blk === '0 && !out_vld && !out_marker && !busy && !done,
              $sformatf("blk=%h v=%b m=%b b=%b d=%b", out_blk, out_vld, out_marker, busy, done),
              "all zero");
        rnd_steps("R8 idle pass", 6, 30);

        // R1 R2 R3 R5: continuous, markers only, alternating lanes, all-ones mask
        set_cfg(0, 0, 4'b1010, 1, 1, 1);
        c_sh = 2'b11; c_bytes = '1;
        step("R5 start", 1, 1, 1, 0);
        rnd_steps("R1 R2 R3 R5 cont", 40, 40);
        // R9: change config while busy
        set_cfg(1, 1, 4'b0101, 2, 0, 1);
        rnd_steps("R9 cfg change", 20, 40);
        // R8: stop while a marker is present
        step("R8 stop", 1, 1, 0, 1);
        rnd_steps("R8 after stop", 8, 50);

        // R4: payload mode
        set_cfg(0, 1, 4'b1111, 1, 1, 1);
        step("R4 start", 1, 0, 1, 0);
        rnd_steps("R4 payload", 30, 20);
        step("R4 stop", 1, 0, 0, 1);

        // R6 R7: markers-only bursts, len 2 gap 3 cnt 3
        set_cfg(1, 0, 4'b1111, 2, 3, 3);
        hits_seen = 0;
        step("R6 start", 0, 0, 1, 0);
        for (int i = 0; i < 400 && m_st != 0; i++) step("R6 R7 burst", 1, ($urandom_range(99) < 40), 0, 0);
        check("R6 hit count", hits_seen == 6, $sformatf("%0d", hits_seen), "6");
        rnd_steps("R7 done hold", 10, 50);

        // R6: payload bursts back to back, zero length treated as one
        set_cfg(1, 1, 4'b0110, 0, 0, 4);
        hits_seen = 0;
        step("R6 start b2b", 1, 0, 1, 0);
        for (int i = 0; i < 400 && m_st != 0; i++) step("R6 b2b", ($urandom_range(99) < 70), 0, 0, 0);
        check("R6 b2b hits", hits_seen == 4, $sformatf("%0d", hits_seen), "4");
        // R7: start clears done
        set_cfg(1, 1, 4'b1111, 5, 5, 5);
        step("R7 restart", 1, 0, 1, 0);
        rnd_steps("R7 restart run", 8, 30);
        // R8: stop mid burst leaves done low; start+stop together ignored
        step("R8 stop mid", 1, 1, 0, 1);
        step("R8 start+stop", 1, 1, 1, 1);
        rnd_steps("R8 idle", 6, 50);

        // Randomised configurations
        for (int k = 0; k < 30; k++) begin
            set_cfg($urandom_range(1), $urandom_range(1), LANES'($urandom()),
                    $urandom_range(4), $urandom_range(3), $urandom_range(4));
            step("R1 R6 rnd start", 1, $urandom_range(1), 1, 0);
            rnd_steps("R1 R3 R4 R6 rnd", 60, 35);
            if ($urandom_range(1)) step("R8 rnd stop", 1, 1, 0, 1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule